// File: doc/BRIEF.md
# Locked Read-Modify-Write Shared Bus Arbiter

This block sits between several requesters and one shared memory bus. Its requesters are processor ports, and the highest-numbered one is normally a DMA engine. Each requester offers one access at a time with a valid/ready handshake. Writes that are not part of a locked sequence are posted: each is parked in a small FIFO owned by its port and drained to memory later. Reads wait on the bus and return the memory data in the cycle they complete. When the bus is free, ownership rotates round-robin among the ports.

A requester starts an atomic read-modify-write by marking its read as locked. An exchange operation marks its read as locked by definition, even when the explicit lock flag is low. The arbiter waits until every port's posted writes have reached memory. It then issues the read and keeps the bus for that requester until the requester's following write has finished.

Any other requester that wants the shared bus during that window is held off. It gets no error and no fault; it simply keeps its request raised until it is served. Accesses that a requester marks as served from its own local memory never touch the bus and are acknowledged at once, even while a lock is held.

Top module: `lock_rmw_arbiter`

## Requirements
- R1: A synchronous active-high reset clears the lock, empties every write FIFO, drops `mem_req`, and sets the round-robin pointer so that port 0 has first priority.
- R2: When no lock is held, the bus is granted round-robin. The search starts at the port after the one granted last, and the pointer moves on every grant.
- R3: A non-local write with no lock held is accepted (`req_ready` high) in the same cycle it is presented, as long as its port's FIFO is not full. The FIFO holds at most `WBD` entries and is drained to memory in order. A read from a port is not issued before that port's own FIFO is empty, so it returns that port's latest posted data.
- R4: A locked read is not issued until every port's FIFO is empty. While a locked read waits for this, `drain_active` is high and no new posted write is accepted from any port.
- R5: When a locked read is granted, `lock_active` goes to 1 and `lock_owner` takes the requester's index. Until that owner's next non-local write has completed on the bus, no other port is granted. `lock_active` returns to 0 at the clock edge on which that write completes.
- R6: A read with `req_xchg` = 1 is treated as locked even when `req_lock` = 0.
- R7: While a lock is held by another port, a requester's non-local write gets `req_ready` = 0 and its bus access waits, with no error indication. It is served after the lock is released.
- R8: An access with `req_local` = 1 gets `req_ready` = 1 in the cycle it is presented, whatever the lock or bus state, and it causes no bus transaction.
- R9: Every bus transaction keeps `mem_req`, `mem_addr` and `gnt_port` steady until `mem_done`. `mem_req` is low for at least one cycle after each `mem_done`, so a locked exchange spans two full memory accesses plus turnaround.
- R10: A non-local read completes with `req_ready` = 1 in the cycle `mem_done` is high for it, with `rsp_data` equal to `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NPORT | Request valid, one bit per port |
| req_write | input | NPORT | 1 = write, 0 = read |
| req_lock | input | NPORT | Lock qualifier on a read |
| req_xchg | input | NPORT | Exchange operation; implies lock on its read |
| req_local | input | NPORT | Access is served from the port's local memory |
| req_addr | input | NPORT*AW | Per-port address, port p at bits p*AW upward |
| req_wdata | input | NPORT*DW | Per-port write data, port p at bits p*DW upward |
| req_ready | output | NPORT | Request accepted/completed this cycle |
| rsp_data | output | DW | Read data for the completing read |
| mem_req | output | 1 | Bus transaction in progress |
| mem_we | output | 1 | Bus transaction is a write |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | DW | Bus write data |
| mem_rdata | input | DW | Memory read data |
| mem_done | input | 1 | Memory finishes the current transaction |
| gnt_port | output | PW | Port that owns the current transaction |
| lock_active | output | 1 | A locked sequence holds the bus |
| lock_owner | output | PW | Port holding the lock |
| drain_active | output | 1 | A locked read waits for the write FIFOs to empty |

## Verification
The bench posts two writes to one address and immediately raises a locked read from another port. If the design skipped the drain, the locked read would return stale data and the grant log would show the read ahead of the second drain. While a lock is held, other ports try a posted write and a plain read. A design that leaked the lock would accept the write or put a foreign port on the bus before the owner's paired write, and the final memory contents would show it. Round-robin order is checked from a non-default pointer, so a fixed-priority picker shows up as the wrong grant sequence. An exchange without the lock flag is checked to set the lock, and local accesses made during a lock are checked to complete without stalling.

// File: rtl/lock_rmw_arbiter.sv
`timescale 1ns/1ps
module lock_rmw_arbiter #(
  parameter int NPORT = 3,
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int WBD   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NPORT-1:0]      req_valid,
  input  logic [NPORT-1:0]      req_write,
  input  logic [NPORT-1:0]      req_lock,
  input  logic [NPORT-1:0]      req_xchg,
  input  logic [NPORT-1:0]      req_local,
  input  logic [NPORT*AW-1:0]   req_addr,
  input  logic [NPORT*DW-1:0]   req_wdata,
  output logic [NPORT-1:0]      req_ready,
  output logic [DW-1:0]         rsp_data,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [AW-1:0]         mem_addr,
  output logic [DW-1:0]         mem_wdata,
  input  logic [DW-1:0]         mem_rdata,
  input  logic                  mem_done,
  output logic [((NPORT>1)?$clog2(NPORT):1)-1:0] gnt_port,
  output logic                  lock_active,
  output logic [((NPORT>1)?$clog2(NPORT):1)-1:0] lock_owner,
  output logic                  drain_active
);
  localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int CW   = $clog2(WBD + 1);
  localparam int PTRW = (WBD > 1) ? $clog2(WBD) : 1;
  localparam int EW   = AW + DW;

  logic [NPORT-1:0] lk, rd_bus, wr_bus, lrd_bus, post_ok, wb_empty, wb_full, cand;
  logic [EW-1:0]    wb_head [NPORT];
  logic             busy, cur_drain, cur_we, found, lock_wait, all_empty, done_now;
  logic [PW-1:0]    cur, last, pick;
  logic [AW-1:0]    cur_addr;
  logic [DW-1:0]    cur_data;

  assign lk        = req_lock | req_xchg;
  assign rd_bus    = req_valid & ~req_write & ~req_local;
  assign wr_bus    = req_valid &  req_write & ~req_local;
  assign lrd_bus   = rd_bus & lk;
  assign all_empty = &wb_empty;
  assign lock_wait = (|lrd_bus) && !lock_active;
  assign drain_active = lock_wait && !all_empty;
  assign done_now  = busy && mem_done;

  assign mem_req   = busy;
  assign mem_we    = cur_we;
  assign mem_addr  = cur_addr;
  assign mem_wdata = cur_data;
  assign gnt_port  = cur;
  assign rsp_data  = mem_rdata;

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    logic [EW-1:0]   q [WBD];
    logic [PTRW-1:0] rp, wp;
    logic [CW-1:0]   cnt;
    logic            push, pop;

    assign wb_empty[i] = (cnt == '0);
    assign wb_full[i]  = (cnt == CW'(WBD));
    assign wb_head[i]  = q[rp];
    assign post_ok[i]  = wr_bus[i] && !lock_active && !lock_wait && !wb_full[i];
    assign push        = post_ok[i];
    assign pop         = done_now && cur_drain && (cur == PW'(i));
    assign cand[i]     = lock_active ? ((lock_owner == PW'(i)) && wr_bus[i])
                                     : (!wb_empty[i] || (rd_bus[i] && (!lk[i] || all_empty)));
    assign req_ready[i] = (req_valid[i] && req_local[i]) || post_ok[i] ||
                          (done_now && !cur_drain && (cur == PW'(i)));

    always_ff @(posedge clk) begin
      if (rst) begin
        rp  <= '0;
        wp  <= '0;
        cnt <= '0;
      end else begin
        if (push) begin
          q[wp] <= {req_addr[i*AW +: AW], req_wdata[i*DW +: DW]};
          wp    <= (wp == PTRW'(WBD - 1)) ? '0 : wp + 1'b1;
        end
        if (pop) rp <= (rp == PTRW'(WBD - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(push) - CW'(pop);
      end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
      cnt <= CW'(WBD)) else $error("R3 write FIFO overflow on port %0d", i);

    a_r7_no_foreign_post: assert property (@(posedge clk) disable iff (rst)
      (lock_active && lock_owner != PW'(i)) |-> !(req_ready[i] && wr_bus[i]))
      else $error("R7 foreign write accepted during lock, port %0d", i);
  end

  always_comb begin
    found = 1'b0;
    pick  = last;
    for (int k = 1; k <= NPORT; k++) begin
      if (!found && cand[(int'(last) + k) % NPORT]) begin
        found = 1'b1;
        pick  = PW'((int'(last) + k) % NPORT);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      cur         <= '0;
      last        <= PW'(NPORT - 1);
      cur_drain   <= 1'b0;
      cur_we      <= 1'b0;
      cur_addr    <= '0;
      cur_data    <= '0;
      lock_active <= 1'b0;
      lock_owner  <= '0;
    end else if (busy) begin
      if (mem_done) begin
        busy <= 1'b0;
        if (lock_active && cur_we) lock_active <= 1'b0;
      end
    end else if (found) begin
      busy <= 1'b1;
      cur  <= pick;
      last <= pick;
      if (!wb_empty[pick] && !lock_active) begin
        cur_drain <= 1'b1;
        cur_we    <= 1'b1;
        cur_addr  <= wb_head[pick][EW-1 -: AW];
        cur_data  <= wb_head[pick][DW-1:0];
      end else begin
        cur_drain <= 1'b0;
        cur_we    <= req_write[pick];
        cur_addr  <= req_addr[int'(pick)*AW +: AW];
        cur_data  <= req_wdata[int'(pick)*DW +: DW];
        if (!req_write[pick] && lk[pick]) begin
          lock_active <= 1'b1;
          lock_owner  <= pick;
        end
      end
    end
  end

  a_r4_drained_before_lock: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_active) |-> all_empty) else $error("R4 lock taken with posted writes pending");

  a_r5_owner_only: assert property (@(posedge clk) disable iff (rst)
    (lock_active && mem_req) |-> (gnt_port == lock_owner)) else $error("R5 foreign grant while locked");

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(gnt_port)))
    else $error("R9 transaction changed before completion");

  a_r9_turnaround: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_done) |=> !mem_req) else $error("R9 missing turnaround cycle");

  a_r8_local_no_bus: assert property (@(posedge clk) disable iff (rst)
    (!mem_req && !(|cand)) |=> !mem_req) else $error("R8 bus started with no bus request");
endmodule

// File: tb/lock_rmw_arbiter_test.sv
`timescale 1ns/1ps
module lock_rmw_arbiter_test;
  localparam int N = 3, AW = 8, DW = 16, WBD = 2, LAT = 3, PW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] req_valid = '0, req_write = '0, req_lock = '0, req_xchg = '0, req_local = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*DW-1:0] req_wdata = '0;
  logic [N-1:0] req_ready;
  logic [DW-1:0] rsp_data, mem_wdata, mem_rdata;
  logic mem_req, mem_we, mem_done, lock_active, drain_active;
  logic [AW-1:0] mem_addr;
  logic [PW-1:0] gnt_port, lock_owner;

  always #2.5 clk = ~clk;

  lock_rmw_arbiter #(.NPORT(N), .AW(AW), .DW(DW), .WBD(WBD)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_lock(req_lock),
    .req_xchg(req_xchg), .req_local(req_local), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_data(rsp_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done),
    .gnt_port(gnt_port), .lock_active(lock_active), .lock_owner(lock_owner),
    .drain_active(drain_active));

  logic [DW-1:0] mem [256];
  int lat_cnt;
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (rst) begin
      mem_done <= 1'b0;
      lat_cnt  <= 0;
      for (int k = 0; k < 256; k++) mem[k] <= DW'(k * 3 + 100);
    end else if (mem_req && !mem_done) begin
      if (lat_cnt == LAT - 1) begin
        mem_done <= 1'b1;
        lat_cnt  <= 0;
        if (mem_we) mem[mem_addr] <= mem_wdata;
      end else lat_cnt <= lat_cnt + 1;
    end else mem_done <= 1'b0;
  end

  int glog [256];
  int gcount = 0, r9_bad = 0;
  logic prev_req, prev_done;
  always @(posedge clk) begin
    if (rst) begin
      prev_req  <= 1'b0;
      prev_done <= 1'b0;
    end else begin
      if (mem_req && !prev_req && gcount < 256) begin
        glog[gcount] <= int'(gnt_port);
        gcount <= gcount + 1;
      end
      if (prev_done && mem_req) r9_bad <= r9_bad + 1;
      if (prev_req && !mem_req && !prev_done) r9_bad <= r9_bad + 1;
      prev_req  <= mem_req;
      prev_done <= mem_req && mem_done;
    end
  end

  int checks = 0, fails = 0;
  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int p, input bit we, input bit lk, input bit xc, input bit loc,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_write[p] = we;  req_lock[p] = lk;  req_xchg[p] = xc;  req_local[p] = loc;
    req_addr[p*AW +: AW] = a;  req_wdata[p*DW +: DW] = d;
    req_valid[p] = 1'b1;
  endtask

  task automatic wait_ready(input int p, output logic [DW-1:0] rd);
    int n = 0;
    #1;
    while (!req_ready[p] && n <= 400) begin
      @(negedge clk); #1; n++;
    end
    if (n > 400) chk("R7 stalled request never served", 0, 1);
    rd = rsp_data;
    @(posedge clk); #1;
    req_valid[p] = 1'b0;
  endtask

  task automatic do_op(input int p, input bit we, input bit lk, input bit xc, input bit loc,
                       input logic [AW-1:0] a, input logic [DW-1:0] d, output logic [DW-1:0] rd);
    drive(p, we, lk, xc, loc, a, d);
    wait_ready(p, rd);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // {port[1:0], write, lock, addr[7:0], wdata[15:0], expected read[15:0]}
  localparam logic [43:0] VEC [9] = '{
    {2'd0, 1'b0, 1'b0, 8'h10, 16'h0000, 16'd148},
    {2'd1, 1'b1, 1'b0, 8'h10, 16'h1234, 16'h0000},
    {2'd1, 1'b0, 1'b0, 8'h10, 16'h0000, 16'h1234},
    {2'd2, 1'b0, 1'b0, 8'h10, 16'h0000, 16'h1234},
    {2'd2, 1'b1, 1'b0, 8'h20, 16'h0AAA, 16'h0000},
    {2'd0, 1'b0, 1'b1, 8'h20, 16'h0000, 16'h0AAA},
    {2'd0, 1'b1, 1'b1, 8'h20, 16'h0BBB, 16'h0000},
    {2'd1, 1'b0, 1'b0, 8'h20, 16'h0000, 16'h0BBB},
    {2'd2, 1'b0, 1'b0, 8'h05, 16'h0000, 16'd115}
  };

  bit finished = 1'b0;

  initial begin
    logic [DW-1:0] rd, rd0, rd1, rd2;
    int b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 reset lock_active", int'(lock_active), 0);
    chk("R1 reset drain_active", int'(drain_active), 0);
    chk("R1 reset mem_req", int'(mem_req), 0);
    chk("R1 reset req_ready", int'(req_ready), 0);

    for (int v = 0; v < 9; v++) begin
      do_op(int'(VEC[v][43:42]), VEC[v][41], VEC[v][40], 1'b0, 1'b0,
            VEC[v][39:32], VEC[v][31:16], rd);
      if (!VEC[v][41]) chk("R10 vector read data", int'(rd), int'(VEC[v][15:0]));
    end
    chk("R5 lock released after paired write", int'(lock_active), 0);

    // R2 round-robin from pointer at port 0
    do_reset();
    do_op(0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, '0, rd);
    b = gcount;
    fork
      do_op(0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, '0, rd0);
      do_op(1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h03, '0, rd1);
      do_op(2, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04, '0, rd2);
    join
    chk("R2 first grant", glog[b], 1);
    chk("R2 second grant", glog[b + 1], 2);
    chk("R2 third grant", glog[b + 2], 0);
    chk("R10 concurrent read port1", int'(rd1), 109);

    // R4 drain before lock, R5 exclusivity, R7 stall
    b = gcount;
    do_op(0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h40, 16'd11, rd);
    do_op(0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h40, 16'd22, rd);
    drive(1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h40, '0);
    #1;
    chk("R4 drain_active while FIFO holds writes", int'(drain_active), 1);
    chk("R4 no lock before drain", int'(lock_active), 0);
    wait_ready(1, rd);
    chk("R4 locked read sees drained data", int'(rd), 22);
    chk("R5 lock_active after locked read", int'(lock_active), 1);
    chk("R5 lock_owner", int'(lock_owner), 1);
    fork
      begin logic [DW-1:0] t; do_op(2, 1'b1, 1'b0, 1'b0, 1'b0, 8'h40, 16'h0777, t); end
      begin do_op(0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h41, '0, rd0); end
    join_none
    repeat (3) @(negedge clk);
    #1;
    chk("R7 foreign write not accepted during lock", int'(req_ready[2]), 0);
    chk("R5 no foreign bus grant during lock", int'(mem_req), 0);
    do_op(1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h40, 16'd33, rd);
    chk("R5 lock cleared after paired write", int'(lock_active), 0);
    wait fork;
    chk("R7 stalled read served after release", int'(rd0), 295);
    do_op(2, 1'b0, 1'b0, 1'b0, 1'b0, 8'h40, '0, rd);
    chk("R3 port read sees own posted write", int'(rd), 16'h0777);
    chk("R5 grant order drain", glog[b + 1], 0);
    chk("R5 grant order locked read", glog[b + 2], 1);
    chk("R5 grant order paired write", glog[b + 3], 1);

    // R6 exchange implies lock, R8 local access during lock
    do_op(2, 1'b0, 1'b0, 1'b1, 1'b0, 8'h50, '0, rd);
    chk("R6 exchange read data", int'(rd), 340);
    chk("R6 exchange sets lock", int'(lock_active), 1);
    chk("R6 exchange lock_owner", int'(lock_owner), 2);
    b = gcount;
    drive(0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h50, '0);
    #1;
    chk("R8 local read ready at once", int'(req_ready[0]), 1);
    wait_ready(0, rd);
    drive(1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h50, 16'hDEAD);
    #1;
    chk("R8 local write ready at once", int'(req_ready[1]), 1);
    wait_ready(1, rd);
    repeat (2) @(negedge clk);
    chk("R8 no bus grant from local access", gcount - b, 0);
    do_op(2, 1'b1, 1'b0, 1'b1, 1'b0, 8'h50, 16'h5A5A, rd);
    chk("R6 lock released by exchange write", int'(lock_active), 0);
    do_op(1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h50, '0, rd);
    chk("R6 exchange write landed", int'(rd), 16'h5A5A);

    // R3 FIFO full back-pressure on a slow bus
    drive(0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h60, 16'd1); wait_ready(0, rd);
    drive(0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h61, 16'd2); wait_ready(0, rd);
    drive(0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h62, 16'd3);
    #1;
    chk("R3 full FIFO holds off write", int'(req_ready[0]), 0);
    wait_ready(0, rd);
    do_op(0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h62, '0, rd);
    chk("R3 back-pressured write reaches memory", int'(rd), 3);

    // R1 reset while locked
    do_op(0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h70, '0, rd);
    chk("R5 lock before reset", int'(lock_active), 1);
    do_reset();
    #1;
    chk("R1 reset clears lock", int'(lock_active), 0);
    chk("R1 reset clears bus", int'(mem_req), 0);
    do_op(1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h70, '0, rd);
    chk("R1 bus usable by others after reset", int'(rd), 436);

    chk("R9 hold and turnaround monitor", r9_bad, 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule